// File: doc/BRIEF.md
# DSI Sync and Line Selector

This block sits in the byte-clock domain directly behind a DSI packet capture engine. It watches the packet engine's decoded data-type field together with its short-packet and long-packet enables. From the short sync packets it builds two registered, active-high levels, a vertical sync and a horizontal sync, for a parallel video output. From the long packets it produces a payload enable. The enable is high only for long packets whose data type equals one configured pixel format, and it steers the byte stream into a downstream pixel parser.

Some hosts send no horizontal-start packet during vertical events. To cover them, the horizontal level is also raised by the vertical start and vertical end packets, unless a parameter turns this off. Blanking, null and all other packet types have no effect on the sync levels and never open the payload enable.

Top module: `dsi_sync_select`

## Requirements
- R1: A short packet (short enable high) with data type 0x01 (vertical start) sets `vsync_o` high in the cycle after the clock edge that samples it.
- R2: A short packet with data type 0x11 (vertical end) clears `vsync_o` low in the cycle after the sampling edge.
- R3: A short packet with data type 0x21 (horizontal start) sets `hsync_o` high in the cycle after the sampling edge. A repeated horizontal start keeps it high.
- R4: A short packet with data type 0x31 (horizontal end) clears `hsync_o` low in the cycle after the sampling edge.
- R5: With the default `HS_ON_VEVT = 1`, a vertical start (0x01) or vertical end (0x11) short packet also sets `hsync_o` high in the cycle after the sampling edge.
- R6: When the short enable is low, both sync outputs keep their value, whatever the data type and whatever the long enable does.
- R7: A short packet whose data type is none of 0x01, 0x11, 0x21 and 0x31 leaves both sync outputs unchanged.
- R8: While `rst_n` is low, both sync outputs are low. The reset is asynchronous and active low.
- R9: With the default `PAY_REG = 0`, `pay_en_o` is combinational. It is high exactly when `long_en_i` is high and the data type equals `PIX_DT` (default 0x3E, a packed 24-bit pixel format). A short packet carrying `PIX_DT` does not raise it.
- R10: A long packet with any other data type never raises `pay_en_o`. Examples are null (0x09), blanking (0x19) and 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_en_i | input | 1 | Short packet header valid this cycle |
| long_en_i | input | 1 | Long packet payload valid this cycle |
| dt_i | input | DT_W | Data type of the current packet |
| vsync_o | output | 1 | Vertical sync level, active high |
| hsync_o | output | 1 | Horizontal sync level, active high |
| pay_en_o | output | 1 | Selected-payload enable for the pixel parser |

## Verification
Each of the four sync codes is sent as a short packet on its own. Pairs are also sent in which a vertical event is followed by a horizontal end. This separates the horizontal level being set by its own code from it being set by a vertical event. Sync codes are then presented with the short enable low, and also while the long enable is high. This shows that the decision is gated by the short enable and not by the data type alone. Finally, matching, non-matching and short-with-matching data types are sent on the payload side, and a reset is applied in the middle of a frame. These show that the enable depends on both the packet kind and the type, and that the reset overrides the sync state.

// File: rtl/dsi_sync_pkg.sv
package dsi_sync_pkg;

   // Decoded sync events, at most one high per cycle
   typedef struct packed {
      logic v_start;
      logic v_end;
      logic h_start;
      logic h_end;
   } sync_evt_t;

   localparam int unsigned EVT_W = $bits(sync_evt_t);

   function automatic logic type_hit(input logic [7:0] a, input logic [7:0] b, input int unsigned w);
      logic [7:0] mask;
      mask = 8'((9'd1 << w) - 9'd1);
      return ((a & mask) == (b & mask));
   endfunction

endpackage

// File: rtl/dsi_sync_decode.sv
module dsi_sync_decode
   import dsi_sync_pkg::*;
#(
   parameter int unsigned         DT_W     = 6,
   parameter logic [DT_W-1:0]     CODE_VS  = 6'h01,
   parameter logic [DT_W-1:0]     CODE_VE  = 6'h11,
   parameter logic [DT_W-1:0]     CODE_HS  = 6'h21,
   parameter logic [DT_W-1:0]     CODE_HE  = 6'h31
) (
   input  logic            short_en_i,
   input  logic [DT_W-1:0] dt_i,
   output sync_evt_t       evt_o
);

   localparam int unsigned N_CODES = 4;
   localparam logic [N_CODES*DT_W-1:0] CODE_VEC = {CODE_VS, CODE_VE, CODE_HS, CODE_HE};

   logic [N_CODES-1:0] hit;

   generate
      for (genvar k = 0; k < N_CODES; k++) begin : g_cmp
         assign hit[k] = short_en_i && (dt_i == CODE_VEC[k*DT_W +: DT_W]);
      end
   endgenerate

   always_comb begin
      evt_o.v_start = hit[3];
      evt_o.v_end   = hit[2];
      evt_o.h_start = hit[1];
      evt_o.h_end   = hit[0];
   end

   always_comb begin
      assert ($onehot0(hit)) else $error("sync codes overlap");
   end

endmodule

// File: rtl/dsi_sync_level.sv
module dsi_sync_level #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end

   AST_NO_SET_CLR_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_i && clr_i)); // R7

endmodule

// File: rtl/dsi_pay_gate.sv
module dsi_pay_gate #(
   parameter int unsigned     DT_W    = 6,
   parameter logic [DT_W-1:0] PIX_DT  = 6'h3E,
   parameter bit              PAY_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            long_en_i,
   input  logic [DT_W-1:0] dt_i,
   output logic            pay_en_o
);

   logic match;
   assign match = long_en_i && (dt_i == PIX_DT);

   generate
      if (PAY_REG) begin : g_reg
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= match;
         end
         assign pay_en_o = q;
      end else begin : g_comb
         assign pay_en_o = match;
      end
   endgenerate

endmodule

// File: rtl/dsi_sync_select.sv
module dsi_sync_select
   import dsi_sync_pkg::*;
#(
   parameter int unsigned     DT_W       = 6,
   parameter logic [DT_W-1:0] PIX_DT     = 6'h3E,
   parameter logic [DT_W-1:0] CODE_VS    = 6'h01,
   parameter logic [DT_W-1:0] CODE_VE    = 6'h11,
   parameter logic [DT_W-1:0] CODE_HS    = 6'h21,
   parameter logic [DT_W-1:0] CODE_HE    = 6'h31,
   parameter bit              HS_ON_VEVT = 1'b1,
   parameter bit              PAY_REG    = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            short_en_i,
   input  logic            long_en_i,
   input  logic [DT_W-1:0] dt_i,
   output logic            vsync_o,
   output logic            hsync_o,
   output logic            pay_en_o
);

   generate
      if (DT_W < 2 || DT_W > 8) begin : g_bad_w
         $error("DT_W must lie in 2..8");
      end
      if (CODE_VS == CODE_VE || CODE_HS == CODE_HE || CODE_VS == CODE_HS || CODE_VE == CODE_HE) begin : g_bad_code
         $error("sync codes must be distinct");
      end
   endgenerate

   sync_evt_t evt;
   logic      h_set;

   dsi_sync_decode #(
      .DT_W(DT_W), .CODE_VS(CODE_VS), .CODE_VE(CODE_VE),
      .CODE_HS(CODE_HS), .CODE_HE(CODE_HE)
   ) u_dec (
      .short_en_i(short_en_i),
      .dt_i      (dt_i),
      .evt_o     (evt)
   );

   generate
      if (HS_ON_VEVT) begin : g_hs_vevt
         assign h_set = evt.h_start || evt.v_start || evt.v_end;
      end else begin : g_hs_only
         assign h_set = evt.h_start;
      end
   endgenerate

   dsi_sync_level #(.RST_VAL(1'b0)) u_vlev (
      .clk(clk), .rst_n(rst_n),
      .set_i(evt.v_start), .clr_i(evt.v_end), .q_o(vsync_o)
   );

   dsi_sync_level #(.RST_VAL(1'b0)) u_hlev (
      .clk(clk), .rst_n(rst_n),
      .set_i(h_set), .clr_i(evt.h_end), .q_o(hsync_o)
   );

   dsi_pay_gate #(.DT_W(DT_W), .PIX_DT(PIX_DT), .PAY_REG(PAY_REG)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .long_en_i(long_en_i), .dt_i(dt_i), .pay_en_o(pay_en_o)
   );

   // ---------------- assertions ----------------
   AST_VS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (short_en_i && dt_i == CODE_VS) |=> vsync_o); // R1
   AST_VS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (short_en_i && dt_i == CODE_VE) |=> !vsync_o); // R2
   AST_HS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (short_en_i && dt_i == CODE_HS) |=> hsync_o); // R3
   AST_HS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (short_en_i && dt_i == CODE_HE) |=> !hsync_o); // R4
   AST_NO_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !short_en_i |=> ($stable(vsync_o) && $stable(hsync_o))); // R6
   AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (short_en_i && dt_i != CODE_VS && dt_i != CODE_VE && dt_i != CODE_HS && dt_i != CODE_HE)
      |=> ($stable(vsync_o) && $stable(hsync_o))); // R7
   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |-> (!vsync_o && !hsync_o)); // R8

   generate
      if (HS_ON_VEVT) begin : g_ast_vevt
         AST_HS_ON_VEVT: assert property (@(posedge clk) disable iff (!rst_n)
            (short_en_i && (dt_i == CODE_VS || dt_i == CODE_VE)) |=> hsync_o); // R5
      end
      if (!PAY_REG) begin : g_ast_pay
         AST_PAY_NEEDS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
            !long_en_i |-> !pay_en_o); // R9
         AST_PAY_BAD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
            (dt_i != PIX_DT) |-> !pay_en_o); // R10
      end
   endgenerate

endmodule

// File: tb/sim_dsi_sync_select.sv
`timescale 1ns/1ps
module sim_dsi_sync_select;

   typedef struct {
      logic  vs;
      logic  hs;
      logic  pay;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       short_en = 1'b0;
   logic       long_en = 1'b0;
   logic [5:0] dt = 6'h00;
   logic       vsync, hsync, pay_en;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;
   exp_t sb[$];

   logic mv = 1'b0;
   logic mh = 1'b0;

   always #2 clk = ~clk;

   dsi_sync_select u0 (
      .clk(clk), .rst_n(rst_n),
      .short_en_i(short_en), .long_en_i(long_en), .dt_i(dt),
      .vsync_o(vsync), .hsync_o(hsync), .pay_en_o(pay_en)
   );

   task automatic step(input logic s, input logic l, input logic [5:0] d, input string req);
      exp_t e;
      @(negedge clk);
      short_en = s; long_en = l; dt = d;
      if (s) begin
         case (d)
            6'h01: begin mv = 1'b1; mh = 1'b1; end
            6'h11: begin mv = 1'b0; mh = 1'b1; end
            6'h21: mh = 1'b1;
            6'h31: mh = 1'b0;
            default: ;
         endcase
      end
      e.vs = mv; e.hs = mh; e.pay = l && (d == 6'h3E); e.req = req;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 6'h00, "R6");
   endtask

   task automatic chk_now(input string req);
      n_tests++;
      if (vsync !== 1'b0 || hsync !== 1'b0) begin
         n_fail++;
         $display("FAIL %s: vs/hs=%b%b expected 00", req, vsync, hsync);
      end
   endtask

   // monitor: compare just after each edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            n_tests++;
            if (vsync !== e.vs || hsync !== e.hs || pay_en !== e.pay) begin
               n_fail++;
               $display("FAIL %s: vs/hs/pay=%b%b%b expected %b%b%b",
                        e.req, vsync, hsync, pay_en, e.vs, e.hs, e.pay);
            end
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not end");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 chk_now("R8");
      @(negedge clk) rst_n = 1'b1;

      step(1'b1, 1'b0, 6'h21, "R3");
      step(1'b1, 1'b0, 6'h21, "R3");
      step(1'b1, 1'b0, 6'h31, "R4");
      step(1'b1, 1'b0, 6'h01, "R1");
      step(1'b1, 1'b0, 6'h31, "R4");
      step(1'b1, 1'b0, 6'h01, "R5");
      idle(2);
      step(1'b0, 1'b0, 6'h11, "R6");
      step(1'b0, 1'b1, 6'h11, "R6");
      step(1'b0, 1'b0, 6'h31, "R6");
      step(1'b1, 1'b0, 6'h08, "R7");
      step(1'b1, 1'b0, 6'h02, "R7");
      step(1'b1, 1'b0, 6'h3E, "R9");
      step(1'b0, 1'b1, 6'h3E, "R9");
      step(1'b0, 1'b1, 6'h3E, "R9");
      step(1'b0, 1'b1, 6'h09, "R10");
      step(1'b0, 1'b1, 6'h19, "R10");
      step(1'b0, 1'b0, 6'h3E, "R9");
      step(1'b1, 1'b0, 6'h31, "R4");
      step(1'b1, 1'b0, 6'h11, "R2");
      step(1'b1, 1'b0, 6'h31, "R4");
      step(1'b1, 1'b0, 6'h11, "R5");
      step(1'b1, 1'b0, 6'h21, "R3");
      step(1'b1, 1'b0, 6'h31, "R4");

      // a few frames: vstart, lines of hstart/payload/hend, vend
      for (int f = 0; f < 3; f++) begin
         step(1'b1, 1'b0, 6'h01, "R1");
         step(1'b1, 1'b0, 6'h31, "R4");
         for (int ln = 0; ln < 4; ln++) begin
            step(1'b1, 1'b0, 6'h21, "R3");
            step(1'b0, 1'b1, (ln == 2) ? 6'h19 : 6'h3E, (ln == 2) ? "R10" : "R9");
            step(1'b0, 1'b1, 6'h3E, "R9");
            step(1'b1, 1'b0, 6'h31, "R4");
         end
         step(1'b1, 1'b0, 6'h11, "R2");
         step(1'b1, 1'b0, 6'h31, "R4");
      end

      // mid-frame reset
      step(1'b1, 1'b0, 6'h01, "R1");
      idle(2);
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b0;
      mv = 1'b0; mh = 1'b0;
      #0.5 chk_now("R8");
      @(negedge clk) rst_n = 1'b1;
      idle(2);
      step(1'b1, 1'b0, 6'h21, "R3");
      idle(1);

      repeat (3) @(posedge clk);
      #1;
      n_tests++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R9: scoreboard left %0d expected 0", sb.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule